// File: doc/BRIEF.md
# Prescaled Event Timer with Alarms and Periodic Taps

The block is a free-running timer for a peripheral subsystem. A source tick, chosen from two tick inputs, advances a 16-bit prescaler while the timer is enabled. Each rise of one fixed prescaler bit advances a main counter. Two periodic channels each watch one prescaler bit picked by software and flag every 0-to-1 transition of that bit. Two alarm channels compare the counter with a programmed value. The counter wrap, and optionally an alarm match, post an overflow event.

Software uses a small register file with plain read and write strobes. Every event sets a sticky status bit and pulses a dedicated event output for one cycle. An interrupt line is raised while any unmasked status bit is set. Tap selections and alarm values do not take effect when written. They pass through a transfer state machine with four states: `SY_IDLE`, `SY_HOLD1`, `SY_HOLD2` and `SY_HOLD3`. Its transitions are `SY_IDLE` to `SY_HOLD1` on an accepted write, `SY_HOLD1` to `SY_HOLD2` and `SY_HOLD2` to `SY_HOLD3` unconditionally, and `SY_HOLD3` to `SY_IDLE` with the new value committed. While the machine is outside `SY_IDLE`, a busy flag is visible and further configuration writes are dropped.

Register map (3-bit address):

| Address | Contents |
|---|---|
| 0 | control: bit0 enable, bit1 clear-on-alarm 0, bit2 clear-on-alarm 1, bit3 source select |
| 1 | status: bit0 overflow, bits 1..2 periodic 0/1, bits 3..4 alarm 0/1, bit5 busy; a write clears the bits written as one |
| 2 | mask: bits 0..4, laid out like status |
| 3, 4 | tap select for periodic 0 and 1 (4 bits) |
| 5, 6 | alarm value for alarm 0 and 1 |
| 7 | counter (read only) |

Top module: `evt_timer`

## Requirements
- R1: After reset, every register reads zero: control, status (busy included), mask, tap selects, alarm values and counter. `irq` and all event outputs are low.
- R2: The prescaler advances once per selected source tick, and only while control bit0 is one. Control bit3 = 1 selects `src_tick[1]`; otherwise `src_tick[0]` is used. The counter advances by one each time prescaler bit 0 rises, which is every second tick.
- R3: When the counter advances from all-ones, it becomes zero, sets status bit0 and pulses `evt_ovf`.
- R4: Periodic channel i sets status bit 1+i and pulses `evt_per[i]` on the tick that makes the prescaler bit named by its tap select go from 0 to 1. This gives one event per 2^(sel+1) ticks.
- R5: Alarm i sets status bit 3+i and pulses `evt_alm[i]` on the counter advance whose new value equals its alarm value. With the timer disabled, no advance and so no match occurs.
- R6: When control bit 1+i is one, a match on alarm i loads the counter with zero instead of the matched value, sets status bit0 and pulses `evt_ovf`.
- R7: `irq` is high exactly when some status bit 0..4 and the same mask bit are both one. Status bits are set whatever the mask holds.
- R8: Writing address 1 clears each status bit written as one. A status bit that is set and cleared on the same edge stays set.
- R9: A write to addresses 3..6 made while not busy takes effect three clock cycles later. Busy (status bit5) is high for exactly those three cycles. Reads of addresses 3..6 return the value in use.
- R10: A write to addresses 3..6 while busy is ignored. An edge or match that occurs inside the transfer window is judged against the old value, so an event due to the new value in that window is missed.
- R11: Events are registered. A pulse appears in the cycle after the edge that sampled its tick and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_tick | input | 2 | Two candidate source tick enables |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| evt_ovf | output | 1 | Overflow event pulse |
| evt_per | output | 2 | Periodic event pulses |
| evt_alm | output | 2 | Alarm event pulses |

## Verification
On every cycle, the embedded properties check the following:
- The prescaler holds while disabled.
- A wrap or alarm clear leaves the counter at zero.
- No event pulse lasts two cycles, and every pulse is matched by its status bit.
- Status bits persist until cleared.
- Busy rises after an accepted transfer request.
- The active configuration changes only when a transfer commits.

Only the bench's scenarios can show the following: periodic rates for given tap selections, counter arithmetic against a reference model, masking of the interrupt line, a write dropped while busy, and an alarm missed because it fell inside the transfer window.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int N_PER = 2;
    localparam int N_ALM = 2;
    localparam int N_EVT = 1 + N_PER + N_ALM;
    localparam int AW    = 3;
    localparam int DW    = 32;

    localparam logic [AW-1:0] A_CTRL  = 3'd0;
    localparam logic [AW-1:0] A_STAT  = 3'd1;
    localparam logic [AW-1:0] A_MASK  = 3'd2;
    localparam logic [AW-1:0] A_TAP0  = 3'd3;
    localparam logic [AW-1:0] A_TAP1  = 3'd4;
    localparam logic [AW-1:0] A_ALM0  = 3'd5;
    localparam logic [AW-1:0] A_ALM1  = 3'd6;
    localparam logic [AW-1:0] A_COUNT = 3'd7;

    localparam int B_EN  = 0;
    localparam int B_CA0 = 1;
    localparam int B_SRC = 3;
    localparam int CTRL_W = 4;

    typedef enum logic [1:0] {
        SY_IDLE,
        SY_HOLD1,
        SY_HOLD2,
        SY_HOLD3
    } sync_state_t;
endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req,
    input  logic [1:0]                     req_idx,
    input  logic [CNT_W-1:0]               req_data,
    output logic                           busy,
    output logic [N_PER-1:0][SEL_W-1:0]    sel_act,
    output logic [N_ALM-1:0][CNT_W-1:0]    alm_act
);
    sync_state_t      state, state_nx;
    logic [1:0]       pend_idx;
    logic [CNT_W-1:0] pend_data;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            SY_IDLE:  state_nx = req ? SY_HOLD1 : SY_IDLE;
            SY_HOLD1: state_nx = SY_HOLD2;
            SY_HOLD2: state_nx = SY_HOLD3;
            SY_HOLD3: state_nx = SY_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SY_IDLE;
        else        state <= state_nx;
    end

    // outputs: capture on accept, commit on leaving the last hold state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_idx  <= '0;
            pend_data <= '0;
            sel_act   <= '0;
            alm_act   <= '0;
        end else begin
            if (state == SY_IDLE && req) begin
                pend_idx  <= req_idx;
                pend_data <= req_data;
            end
            if (state == SY_HOLD3) begin
                for (int i = 0; i < N_PER; i++)
                    if (pend_idx == 2'(i)) sel_act[i] <= pend_data[SEL_W-1:0];
                for (int j = 0; j < N_ALM; j++)
                    if (pend_idx == 2'(N_PER + j)) alm_act[j] <= pend_data;
            end
        end
    end

    assign busy = (state != SY_IDLE);

    p_busy_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);
    p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    p_cfg_only_on_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SY_HOLD3) |=> ($stable(sel_act) && $stable(alm_act)));
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PSC_W   = 16,
    parameter int SEL_W   = 4,
    parameter int CNT_TAP = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic                        tick,
    input  logic [N_ALM-1:0]            clr_on_alm,
    input  logic [N_PER-1:0][SEL_W-1:0] sel_act,
    input  logic [N_ALM-1:0][CNT_W-1:0] alm_act,
    output logic [CNT_W-1:0]            cnt,
    output logic                        ev_ovf,
    output logic [N_PER-1:0]            ev_per,
    output logic [N_ALM-1:0]            ev_alm
);
    logic [PSC_W-1:0] psc, psc_nx;
    logic [CNT_W-1:0] cnt_inc;
    logic             adv, step, wrap, clr;

    assign adv     = en && tick;
    assign psc_nx  = psc + 1'b1;
    assign step    = adv && !psc[CNT_TAP] && psc_nx[CNT_TAP];
    assign cnt_inc = cnt + 1'b1;

    for (genvar i = 0; i < N_PER; i++) begin : g_per
        assign ev_per[i] = adv && !psc[sel_act[i]] && psc_nx[sel_act[i]];
    end

    for (genvar j = 0; j < N_ALM; j++) begin : g_alm
        assign ev_alm[j] = step && (cnt_inc == alm_act[j]);
    end

    assign wrap   = step && (&cnt);
    assign clr    = |(ev_alm & clr_on_alm);
    assign ev_ovf = wrap || clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc <= '0;
            cnt <= '0;
        end else begin
            if (adv)  psc <= psc_nx;
            if (step) cnt <= clr ? '0 : cnt_inc;
        end
    end

    p_psc_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(psc));
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (&cnt)) |=> (cnt == '0));
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && clr) |=> (cnt == '0));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PSC_W   = 16,
    parameter int CNT_TAP = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    src_tick,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [2:0]    rd_addr,
    output logic [31:0]   rd_data,
    output logic          irq,
    output logic          evt_ovf,
    output logic [1:0]    evt_per,
    output logic [1:0]    evt_alm
);
    localparam int SEL_W = $clog2(PSC_W);

    logic [CTRL_W-1:0]           ctrl_q;
    logic [N_EVT-1:0]            mask_q, stat_q, evt_q, ev_vec, clr_mask;
    logic                        tick, busy, req;
    logic [1:0]                  req_idx;
    logic [N_PER-1:0][SEL_W-1:0] sel_act;
    logic [N_ALM-1:0][CNT_W-1:0] alm_act;
    logic [CNT_W-1:0]            cnt;
    logic                        ev_ovf;
    logic [N_PER-1:0]            ev_per;
    logic [N_ALM-1:0]            ev_alm;

    assign tick    = ctrl_q[B_SRC] ? src_tick[1] : src_tick[0];
    assign req     = wr_en && (wr_addr >= A_TAP0) && (wr_addr <= A_ALM1);
    assign req_idx = 2'(wr_addr - A_TAP0);

    evt_timer_sync #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_idx  (req_idx),
        .req_data (wr_data[CNT_W-1:0]),
        .busy     (busy),
        .sel_act  (sel_act),
        .alm_act  (alm_act)
    );

    evt_timer_core #(.CNT_W(CNT_W), .PSC_W(PSC_W), .SEL_W(SEL_W),
                     .CNT_TAP(CNT_TAP)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl_q[B_EN]),
        .tick       (tick),
        .clr_on_alm (ctrl_q[B_CA0 +: N_ALM]),
        .sel_act    (sel_act),
        .alm_act    (alm_act),
        .cnt        (cnt),
        .ev_ovf     (ev_ovf),
        .ev_per     (ev_per),
        .ev_alm     (ev_alm)
    );

    assign ev_vec   = {ev_alm, ev_per, ev_ovf};
    assign clr_mask = (wr_en && wr_addr == A_STAT) ? wr_data[N_EVT-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            stat_q <= '0;
            evt_q  <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_en && wr_addr == A_MASK) mask_q <= wr_data[N_EVT-1:0];
            stat_q <= (stat_q & ~clr_mask) | ev_vec;
            evt_q  <= ev_vec;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  rd_data = 32'(ctrl_q);
            A_STAT:  rd_data = 32'({busy, stat_q});
            A_MASK:  rd_data = 32'(mask_q);
            A_TAP0:  rd_data = 32'(sel_act[0]);
            A_TAP1:  rd_data = 32'(sel_act[1]);
            A_ALM0:  rd_data = 32'(alm_act[0]);
            A_ALM1:  rd_data = 32'(alm_act[1]);
            A_COUNT: rd_data = 32'(cnt);
        endcase
    end

    assign irq     = |(stat_q & mask_q);
    assign evt_ovf = evt_q[0];
    assign evt_per = evt_q[1 +: N_PER];
    assign evt_alm = evt_q[1 + N_PER +: N_ALM];

    p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    p_pulse_has_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~stat_q) == '0));
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q != '0) |=> ((evt_q & $past(evt_q)) == '0));
endmodule

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, evt_ovf;
    logic [1:0]  evt_per, evt_alm;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0, cmp_on = 0;

    always #2.5 clk = ~clk;

    evt_timer #(.CNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .evt_ovf(evt_ovf),
        .evt_per(evt_per), .evt_alm(evt_alm)
    );

    // reference model of the requirements
    logic [15:0]     m_psc;
    logic [7:0]      m_cnt;
    logic [3:0]      m_ctrl;
    logic [4:0]      m_mask, m_stat, m_evt;
    logic [1:0][3:0] m_sel;
    logic [1:0][7:0] m_alm;
    int              m_cd;
    logic [1:0]      m_pidx;
    logic [7:0]      m_pdata;

    always @(posedge clk) begin : model
        logic        t, stp, clr;
        logic [15:0] pn;
        logic [7:0]  ci;
        logic [4:0]  ev, clrm;
        if (!rst_n) begin
            m_psc = '0; m_cnt = '0; m_ctrl = '0; m_mask = '0; m_stat = '0;
            m_evt = '0; m_sel = '0; m_alm = '0; m_cd = 0; m_pidx = '0; m_pdata = '0;
        end else begin
            t  = m_ctrl[0] && (m_ctrl[3] ? src_tick[1] : src_tick[0]);
            pn = m_psc + 16'd1;
            ev = '0;
            for (int i = 0; i < 2; i++)
                if (t && !m_psc[m_sel[i]] && pn[m_sel[i]]) ev[1+i] = 1'b1;
            stp = t && !m_psc[0] && pn[0];
            if (stp) begin
                ci = m_cnt + 8'd1;
                for (int i = 0; i < 2; i++) if (ci == m_alm[i]) ev[3+i] = 1'b1;
                clr = (ev[3] && m_ctrl[1]) || (ev[4] && m_ctrl[2]);
                if (m_cnt == 8'hff || clr) ev[0] = 1'b1;
                m_cnt = clr ? 8'd0 : ci;
            end
            if (t) m_psc = pn;
            clrm   = (wr_en && wr_addr == 3'd1) ? wr_data[4:0] : 5'd0;
            m_stat = (m_stat & ~clrm) | ev;
            m_evt  = ev;
            if (wr_en && wr_addr == 3'd0) m_ctrl = wr_data[3:0];
            if (wr_en && wr_addr == 3'd2) m_mask = wr_data[4:0];
            if (m_cd != 0) begin
                m_cd = m_cd - 1;
                if (m_cd == 0) begin
                    if (m_pidx < 2) m_sel[m_pidx] = m_pdata[3:0];
                    else            m_alm[m_pidx-2] = m_pdata;
                end
            end else if (wr_en && wr_addr >= 3'd3 && wr_addr <= 3'd6) begin
                m_cd = 3; m_pidx = 2'(wr_addr - 3'd3); m_pdata = wr_data[7:0];
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return 32'(m_ctrl);
            3'd1: return 32'({(m_cd != 0), m_stat});
            3'd2: return 32'(m_mask);
            3'd3: return 32'(m_sel[0]);
            3'd4: return 32'(m_sel[1]);
            3'd5: return 32'(m_alm[0]);
            3'd6: return 32'(m_alm[1]);
            default: return 32'(m_cnt);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        check("R7 irq", 32'(irq), 32'(|(m_stat & m_mask)));
        check("R3/R6/R11 evt_ovf", 32'(evt_ovf), 32'(m_evt[0]));
        check("R4/R11 evt_per", 32'(evt_per), 32'(m_evt[2:1]));
        check("R5/R11 evt_alm", 32'(evt_alm), 32'(m_evt[4:3]));
        check("R9 rd_data", rd_data, exp_rd(rd_addr));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (cmp_on) compare();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_cd != 0) step();
    endtask

    task automatic rdchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a; #0.5;
        check(tag, rd_data, exp);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        logic [7:0]  c;
        int          n;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        for (int a = 0; a < 8; a++) rdchk("R1 reset reg", 3'(a), 32'd0);
        check("R1 irq", 32'(irq), 0);
        check("R1 events", 32'({evt_ovf, evt_per, evt_alm}), 0);
        cmp_on = 1;

        // configure
        wr(3'd2, 32'h1f);
        wr(3'd3, 32'd0); wait_idle();
        wr(3'd4, 32'd2); wait_idle();
        wr(3'd5, 32'd6); wait_idle();
        wr(3'd6, 32'd200); wait_idle();
        wr(3'd0, 32'd1);

        // R4: tap 0 with continuous ticks gives a pulse every two cycles
        src_tick = 2'b01;
        n = 0;
        for (int k = 0; k < 16; k++) begin step(); n += evt_per[0]; end
        check("R4 tap0 pulse count", 32'(n), 32'd8);

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            src_tick = 2'($urandom_range(0, 3));
            rd_addr  = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) begin
                wr_en = 1'b1; wr_addr = 3'($urandom_range(0, 7));
                wr_data = $urandom();
                if (wr_addr == 3'd0 && $urandom_range(0, 3) != 0) wr_data[0] = 1'b1;
                if (wr_addr == 3'd5 || wr_addr == 3'd6) wr_data[7:0] = 8'($urandom_range(0, 15));
            end
            step();
            wr_en = 1'b0;
        end
        src_tick = 2'b00;
        wait_idle();

        // R9/R10: busy after write, old value visible, second write dropped
        wr(3'd3, 32'd3);
        rdchk("R9 busy set", 3'd1, 32'(exp_rd(3'd1)) | 32'h20);
        rdchk("R9 old value in use", 3'd3, exp_rd(3'd3));
        wr(3'd3, 32'd7);
        wait_idle();
        rdchk("R10 write while busy ignored", 3'd3, 32'd3);

        // R2: disabled timer does not count; source select
        wr(3'd0, 32'd0);
        c = m_cnt;
        src_tick = 2'b11;
        repeat (10) step();
        rdchk("R2 disabled holds", 3'd7, 32'(c));
        src_tick = 2'b00;
        wr(3'd0, 32'h9);
        src_tick = 2'b01;
        repeat (10) step();
        rdchk("R2 unselected source ignored", 3'd7, 32'(c));
        src_tick = 2'b10;
        repeat (4) step();
        rdchk("R2 selected source counts", 3'd7, 32'(8'(c + 8'd2)));

        // R10: alarm written inside its own window is missed
        src_tick = 2'b00;
        wr(3'd0, 32'd1);
        wr(3'd6, 32'(8'(m_cnt + 8'd128))); wait_idle();
        wr(3'd1, 32'h1f);
        c = m_cnt;
        wr(3'd6, 32'(8'(c + 8'd1)));
        src_tick = 2'b01;
        repeat (3) step();
        src_tick = 2'b00;
        rd_addr = 3'd1; #0.5;
        check("R10 missed alarm", 32'(rd_data[4]), 32'd0);
        rdchk("R9 new alarm applied", 3'd6, 32'(8'(c + 8'd1)));

        // R6: clear on alarm 0 keeps counter below the alarm value
        wr(3'd6, 32'd250); wait_idle();
        wr(3'd5, 32'd4); wait_idle();
        wr(3'd0, 32'h3);
        src_tick = 2'b01;
        repeat (600) step();
        wr(3'd1, 32'h1f);
        rd_addr = 3'd7;
        for (int k = 0; k < 40; k++) begin
            step();
            check("R6 counter below alarm", 32'(rd_data < 32'd4), 32'd1);
        end
        src_tick = 2'b00;
        step();
        rd_addr = 3'd1; #0.5;
        check("R6 overflow posted", 32'(rd_data[0]), 32'd1);
        check("R5 alarm0 status", 32'(rd_data[3]), 32'd1);

        // R7: mask gates irq
        wr(3'd2, 32'd0);
        check("R7 masked irq low", 32'(irq), 32'd0);
        wr(3'd2, 32'd1);
        check("R7 unmasked irq high", 32'(irq), 32'd1);

        // R8: clear by writing ones
        wr(3'd1, 32'h1f);
        rdchk("R8 status cleared", 3'd1, 32'd0);
        check("R8 irq after clear", 32'(irq), 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule